// File: doc/BRIEF.md
# Command Stream Register-Write Decoder

The block consumes a stream of 32-bit command words over a valid/ready handshake. Each header word selects, through its top four bits, how the words after it are interpreted. The decoder turns those headers and payloads into register-write transactions, each carrying the current class, a 12-bit register offset and 32 bits of data.

Payload words can be written to a run of consecutive offsets, all to one fixed offset, or sparsely to offsets picked out by a bitmask. An immediate header writes a 16-bit value with no payload at all. Two header kinds produce no writes. Instead they raise one-cycle requests to an external fetch unit: a jump to a new byte address, or a fetch of extra words with a count, an optional offset and a mode flag.

The block is stalled only by its write output. While a produced write waits for acceptance, the command input stays not ready, so no word is lost.

Top module: `cmd_write_decoder`

## Requirements
- R1: After reset the current class is 0, `wr_valid`, `jump_valid`, `fetch_valid` and `bad_opcode` are low, `cmd_ready` is high, and the next accepted word is decoded as a header.
- R2: A header with opcode 0 (bits [31:28]) latches bits [15:6] as the class used by every later write. A non-zero bits [5:0] consumes one payload word per set bit, lowest bit first, each written to offset (bits [27:16]) plus the bit index under the new class.
- R3: Opcode 1 takes a count from bits [15:0]. That many payload words are written to offset, offset+1, offset+2 and so on, in arrival order.
- R4: Opcode 2 takes a count from bits [15:0]. That many payload words are all written to the header's offset.
- R5: Opcode 3 takes a 16-bit mask from bits [15:0]. One payload word is consumed per set bit, in order from lowest bit to highest, and bit i writes to offset+i.
- R6: Opcode 4 consumes no payload and writes bits [15:0], zero-extended to 32 bits, to the header's offset.
- R7: Opcode 5 raises `jump_valid` for exactly one cycle, in the cycle after the header is accepted, with `jump_addr` equal to bits [27:0] shifted left by 4.
- R8: Opcode 6 raises `fetch_valid` for one cycle, in the cycle after acceptance. `fetch_count` carries bits [13:0], `fetch_has_offset` carries bit 15, and `fetch_incr` carries bit 14. `fetch_offset` carries bits [27:16] when bit 15 is set and 0 otherwise. At most one of the two request pulses is high in any cycle.
- R9: A header with opcode 1 or 2 and a zero count, or opcode 0 or 3 and a zero mask, produces no write and consumes no payload. This includes the all-zero-fields opcode 2 no-op. The next word is decoded as a header.
- R10: Opcodes 7 to 15 set `bad_opcode`, which stays high until reset. The word produces no output, and the next word is decoded as a header.
- R11: While `wr_valid` is high and `wr_ready` is low, the write fields hold steady and `cmd_ready` is low. No accepted payload word is ever dropped.
- R12: Offset arithmetic is modulo 4096. An increment past 0xFFF, or offset plus mask bit index past 0xFFF, wraps to low offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word may be accepted |
| cmd_word | input | 32 | Header or payload word |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Register write taken |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 12 | Register offset of the write |
| wr_data | output | 32 | Write data |
| jump_valid | output | 1 | One-cycle jump request |
| jump_addr | output | 32 | Jump byte address |
| fetch_valid | output | 1 | One-cycle fetch request |
| fetch_count | output | 14 | Words to fetch |
| fetch_offset | output | 12 | Offset for fetched words |
| fetch_has_offset | output | 1 | Fetched words carry their own offset |
| fetch_incr | output | 1 | Fetched words go to consecutive offsets |
| bad_opcode | output | 1 | Sticky unknown-opcode flag |

## Verification
The assertions rely on `cmd_word` being stable only within a cycle where `cmd_valid` is sampled. They make no assumption about `wr_ready`, which may drop at any time, including in the middle of a payload run. The stimulus respects the handshake. It holds each word until it sees `cmd_ready` high before a rising edge. It toggles `wr_ready` through a fixed irregular pattern, with one long stall, so that runs, sparse masks and immediates all meet backpressure.

// File: rtl/cmdw_pkg.sv
package cmdw_pkg;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 12;
  localparam int CLS_W  = 10;
  localparam int CNT_W  = 16;
  localparam int MASK_W = 16;
  localparam int IDX_W  = $clog2(MASK_W);
  localparam int GCNT_W = 14;
  localparam int ADDR_W = 32;
  localparam int JSH    = 4;
  localparam int SCM_W  = 6;

  localparam logic [3:0] OP_SETCLASS = 4'd0;
  localparam logic [3:0] OP_INCR     = 4'd1;
  localparam logic [3:0] OP_NONINCR  = 4'd2;
  localparam logic [3:0] OP_MASK     = 4'd3;
  localparam logic [3:0] OP_IMM      = 4'd4;
  localparam logic [3:0] OP_RESTART  = 4'd5;
  localparam logic [3:0] OP_GATHER   = 4'd6;

  typedef enum logic [1:0] {ST_HDR, ST_RUN, ST_SPARSE} st_e;

  typedef struct packed {
    logic [3:0]              op;
    logic [OFF_W-1:0]        off;
    logic [CLS_W-1:0]        cls;
    logic [SCM_W-1:0]        cmask;
    logic [CNT_W-1:0]        low16;
    logic [ADDR_W-JSH-1:0]   addr_hi;
    logic                    g_has_off;
    logic                    g_incr;
    logic [GCNT_W-1:0]       gcnt;
  } hdr_t;

  // index of the lowest set bit (0 when none set)
  function automatic logic [IDX_W-1:0] low_bit(input logic [MASK_W-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = MASK_W - 1; i >= 0; i--) if (m[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [MASK_W-1:0] clear_low(input logic [MASK_W-1:0] m);
    return m & (m - MASK_W'(1));
  endfunction

  function automatic logic [OFF_W-1:0] off_add(input logic [OFF_W-1:0] base,
                                                input logic [IDX_W-1:0] idx);
    return base + OFF_W'(idx);
  endfunction
endpackage

// File: rtl/cmdw_decode.sv
module cmdw_decode
  import cmdw_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_t              hdr
);
  always_comb begin
    hdr.op        = word[31:28];
    hdr.off       = word[27:16];
    hdr.cls       = word[15:6];
    hdr.cmask     = word[5:0];
    hdr.low16     = word[15:0];
    hdr.addr_hi   = word[ADDR_W-JSH-1:0];
    hdr.g_has_off = word[15];
    hdr.g_incr    = word[14];
    hdr.gcnt      = word[GCNT_W-1:0];
  end
endmodule

// File: rtl/cmdw_sequencer.sv
module cmdw_sequencer
  import cmdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WORD_W-1:0] word,
  input  hdr_t              hdr,
  output logic              gen_write,
  output logic [OFF_W-1:0]  gen_off,
  output logic [WORD_W-1:0] gen_data,
  output logic              load_class,
  output logic              jump_fire,
  output logic              fetch_fire,
  output logic              bad_op
);
  st_e               st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              step_q, step_d;
  logic [MASK_W-1:0] mask_rest;

  assign mask_rest = clear_low(mask_q);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; off_d = off_q; mask_d = mask_q; step_d = step_q;
    gen_write = 1'b0; gen_off = '0; gen_data = '0;
    load_class = 1'b0; jump_fire = 1'b0; fetch_fire = 1'b0; bad_op = 1'b0;
    if (accept) begin
      case (st_q)
        ST_HDR: begin
          case (hdr.op)
            OP_SETCLASS: begin
              load_class = 1'b1;
              mask_d = MASK_W'(hdr.cmask);
              off_d  = hdr.off;
              if (hdr.cmask != '0) st_d = ST_SPARSE;
            end
            OP_INCR, OP_NONINCR: begin
              cnt_d  = hdr.low16;
              off_d  = hdr.off;
              step_d = (hdr.op == OP_INCR);
              if (hdr.low16 != '0) st_d = ST_RUN;
            end
            OP_MASK: begin
              mask_d = hdr.low16;
              off_d  = hdr.off;
              if (hdr.low16 != '0) st_d = ST_SPARSE;
            end
            OP_IMM: begin
              gen_write = 1'b1;
              gen_off   = hdr.off;
              gen_data  = WORD_W'(hdr.low16);
            end
            OP_RESTART: jump_fire  = 1'b1;
            OP_GATHER:  fetch_fire = 1'b1;
            default:    bad_op     = 1'b1;
          endcase
        end
        ST_RUN: begin
          gen_write = 1'b1;
          gen_off   = off_q;
          gen_data  = word;
          cnt_d     = cnt_q - CNT_W'(1);
          if (step_q) off_d = off_q + OFF_W'(1);
          if (cnt_q == CNT_W'(1)) st_d = ST_HDR;
        end
        ST_SPARSE: begin
          gen_write = 1'b1;
          gen_off   = off_add(off_q, low_bit(mask_q));
          gen_data  = word;
          mask_d    = mask_rest;
          if (mask_rest == '0) st_d = ST_HDR;
        end
        default: st_d = ST_HDR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_HDR; cnt_q <= '0; off_q <= '0; mask_q <= '0; step_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; off_q <= off_d; mask_q <= mask_d; step_q <= step_d;
    end
  end

  assert_run_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && st_q == ST_RUN) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_fixed_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && st_q == ST_RUN && !step_q) |=> (off_q == $past(off_q)));
  assert_mask_shrink_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && st_q == ST_SPARSE) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(st_q) && $stable(cnt_q) && $stable(mask_q) && $stable(off_q)));
endmodule

// File: rtl/cmdw_outreg.sv
module cmdw_outreg
  import cmdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CLS_W-1:0]  in_cls,
  input  logic [OFF_W-1:0]  in_off,
  input  logic [WORD_W-1:0] in_data,
  input  logic              out_ready,
  output logic              slot_free,
  output logic              out_valid,
  output logic [CLS_W-1:0]  out_cls,
  output logic [OFF_W-1:0]  out_off,
  output logic [WORD_W-1:0] out_data
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_cls <= '0; out_off <= '0; out_data <= '0;
    end else if (load) begin
      out_valid <= 1'b1; out_cls <= in_cls; out_off <= in_off; out_data <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_off) && $stable(out_cls)));
  assert_no_clobber_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> slot_free);
endmodule

// File: rtl/cmd_write_decoder.sv
module cmd_write_decoder
  import cmdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [CLS_W-1:0]  wr_class,
  output logic [OFF_W-1:0]  wr_offset,
  output logic [WORD_W-1:0] wr_data,
  output logic              jump_valid,
  output logic [ADDR_W-1:0] jump_addr,
  output logic              fetch_valid,
  output logic [GCNT_W-1:0] fetch_count,
  output logic [OFF_W-1:0]  fetch_offset,
  output logic              fetch_has_offset,
  output logic              fetch_incr,
  output logic              bad_opcode
);
  hdr_t              hdr;
  logic              accept, slot_free;
  logic              gen_write, load_class, jump_fire, fetch_fire, bad_op;
  logic [OFF_W-1:0]  gen_off;
  logic [WORD_W-1:0] gen_data;
  logic [CLS_W-1:0]  class_q;

  assign cmd_ready = slot_free;
  assign accept    = cmd_valid && cmd_ready;

  cmdw_decode u_dec (.word(cmd_word), .hdr(hdr));

  cmdw_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .word(cmd_word), .hdr(hdr),
    .gen_write(gen_write), .gen_off(gen_off), .gen_data(gen_data),
    .load_class(load_class), .jump_fire(jump_fire), .fetch_fire(fetch_fire),
    .bad_op(bad_op));

  cmdw_outreg u_out (
    .clk(clk), .rst_n(rst_n), .load(gen_write), .in_cls(class_q), .in_off(gen_off),
    .in_data(gen_data), .out_ready(wr_ready), .slot_free(slot_free),
    .out_valid(wr_valid), .out_cls(wr_class), .out_off(wr_offset), .out_data(wr_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      class_q <= '0; jump_valid <= 1'b0; jump_addr <= '0;
      fetch_valid <= 1'b0; fetch_count <= '0; fetch_offset <= '0;
      fetch_has_offset <= 1'b0; fetch_incr <= 1'b0; bad_opcode <= 1'b0;
    end else begin
      if (load_class) class_q <= hdr.cls;
      jump_valid  <= jump_fire;
      fetch_valid <= fetch_fire;
      if (jump_fire) jump_addr <= {hdr.addr_hi, {JSH{1'b0}}};
      if (fetch_fire) begin
        fetch_count      <= hdr.gcnt;
        fetch_has_offset <= hdr.g_has_off;
        fetch_incr       <= hdr.g_incr;
        fetch_offset     <= hdr.g_has_off ? hdr.off : '0;
      end
      if (bad_op) bad_opcode <= 1'b1;
    end
  end

  assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({jump_valid, fetch_valid}));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_opcode |=> bad_opcode);
  assert_jump_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |-> (jump_addr[JSH-1:0] == '0));
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !accept);
endmodule

// File: tb/test_cmd_write_decoder.sv
module test_cmd_write_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, wr_ready = 1'b1;
  logic [31:0] cmd_word = '0;
  logic cmd_ready, wr_valid, jump_valid, fetch_valid, fetch_has_offset, fetch_incr, bad_opcode;
  logic [9:0] wr_class; logic [11:0] wr_offset, fetch_offset; logic [31:0] wr_data, jump_addr;
  logic [13:0] fetch_count;

  always #5 clk = ~clk;

  cmd_write_decoder i_cmd_write_decoder (.*);

  typedef struct { int cls; int off; logic [31:0] data; string tag; } wr_t;
  wr_t exp_q[$];
  int total = 0, bad = 0, cyc = 0;
  int mode = 0, remaining = 0, base = 0, cls = 0, pmask = 0; bit stepping = 0;
  bit ej = 0, ef = 0, eerr = 0, ef_has = 0, ef_inc = 0;
  logic [31:0] eja = 0; int ef_cnt = 0, ef_off = 0;
  bit was_stall = 0; logic [31:0] stall_data; logic [11:0] stall_off;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic push(input int off, input logic [31:0] d, input string tag);
    wr_t e; e.cls = cls; e.off = off % 4096; e.data = d; e.tag = tag; exp_q.push_back(e);
  endtask

  // behavioural model: consume one accepted word
  task automatic model(input logic [31:0] w);
    int op, i;
    if (mode == 1) begin
      push(base, w, stepping ? (base == 4095 ? "R12" : "R3") : "R4");
      if (stepping) base = (base + 1) % 4096;
      remaining--; if (remaining == 0) mode = 0;
    end else if (mode == 2) begin
      i = 0; while (((pmask >> i) & 1) == 0) i++;
      push(base + i, w, (base + i > 4095) ? "R12" : "R5");
      pmask = pmask & ~(1 << i); if (pmask == 0) mode = 0;
    end else begin
      op = int'(w[31:28]);
      if (op == 0) begin cls = int'(w[15:6]); base = int'(w[27:16]); pmask = int'(w[5:0]); mode = (pmask != 0) ? 2 : 0; end
      else if (op == 1 || op == 2) begin remaining = int'(w[15:0]); base = int'(w[27:16]); stepping = (op == 1); mode = (remaining != 0) ? 1 : 0; end
      else if (op == 3) begin pmask = int'(w[15:0]); base = int'(w[27:16]); mode = (pmask != 0) ? 2 : 0; end
      else if (op == 4) push(int'(w[27:16]), {16'h0, w[15:0]}, cls == 0 ? "R1" : "R6");
      else if (op == 5) begin ej = 1; eja = {w[27:0], 4'h0}; end
      else if (op == 6) begin ef = 1; ef_cnt = int'(w[13:0]); ef_has = w[15]; ef_inc = w[14]; ef_off = w[15] ? int'(w[27:16]) : 0; end
      else eerr = 1;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(jump_valid == ej, "R7", 64'(jump_valid), 64'(ej));
      if (ej) chk(jump_addr == eja, "R7", 64'(jump_addr), 64'(eja));
      chk(fetch_valid == ef, "R8", 64'(fetch_valid), 64'(ef));
      if (ef) chk(fetch_count == 14'(ef_cnt) && fetch_offset == 12'(ef_off) && fetch_has_offset == ef_has && fetch_incr == ef_inc,
                  "R8", {fetch_count, fetch_offset, fetch_has_offset, fetch_incr}, {14'(ef_cnt), 12'(ef_off), ef_has, ef_inc});
      chk(bad_opcode == eerr, "R10", 64'(bad_opcode), 64'(eerr));
      if (was_stall) chk(wr_valid && wr_data == stall_data && wr_offset == stall_off, "R11", {wr_offset, wr_data}, {stall_off, stall_data});
      was_stall = wr_valid && !wr_ready; stall_data = wr_data; stall_off = wr_offset;
      if (wr_valid && !wr_ready) chk(!cmd_ready, "R11", 64'(cmd_ready), 64'd0);
      ej = 0; ef = 0;
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R9", {wr_offset, wr_data}, 64'd0);
        else begin
          wr_t e; e = exp_q.pop_front();
          chk(wr_class == 10'(e.cls) && wr_offset == 12'(e.off) && wr_data == e.data, e.tag,
              {wr_class, wr_offset, wr_data}, {10'(e.cls), 12'(e.off), e.data});
        end
      end
      if (cmd_valid && cmd_ready) model(cmd_word);
    end
  end

  task automatic send(input logic [31:0] w);
    cmd_valid = 1'b1; cmd_word = w;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1; cmd_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      wr_ready = !((cyc % 5 == 3) || (cyc % 7 == 0) || (cyc > 60 && cyc < 68));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++; $display("FAIL R11 watchdog actual=hung expected=finished");
    summary; $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk(cmd_ready == 1 && wr_valid == 0 && bad_opcode == 0 && jump_valid == 0 && fetch_valid == 0,
        "R1", {cmd_ready, wr_valid, bad_opcode, jump_valid, fetch_valid}, 64'h10);
    rst_n = 1'b1;
    send(32'h4044_1234);                       // R1: class 0 after reset
    send(32'h0010_0A65);                       // R2: class 0x29, mask 100101
    for (int i = 0; i < 3; i++) send(32'hC000_0000 + i);
    send(32'h1100_0003);                       // R3
    for (int i = 0; i < 3; i++) send(32'hA000_0010 + i);
    send(32'h2020_0002);                       // R4
    for (int i = 0; i < 2; i++) send(32'hB000_0020 + i);
    send(32'h3030_8001);                       // R5
    for (int i = 0; i < 2; i++) send(32'hD000_0030 + i);
    send(32'h4044_BEEF);                       // R6
    send(32'h2000_0000);                       // R9 no-op
    send(32'h1005_0000);                       // R9 zero count
    send(32'h3006_0000);                       // R9 zero mask
    send(32'h5000_0123);                       // R7
    send(32'h6000_0010);                       // R8 plain
    send(32'h6ABC_C005);                       // R8 with offset, incrementing
    send(32'h6ABC_4007);                       // R8 bit 15 clear: offset 0
    send(32'h9123_4567);                       // R10 unknown opcode
    send(32'h1FFE_0003);                       // R12 wrap
    for (int i = 0; i < 3; i++) send(32'hE000_0040 + i);
    send(32'h3FF8_0300);                       // R12 sparse wrap: 0xFF8+8, +9
    for (int i = 0; i < 2; i++) send(32'hF000_0050 + i);
    send(32'h0000_FFC0);                       // R2 class 0x3FF, mask 0
    send(32'h4001_0042);                       // R6 with new class
    send(32'h2077_0014);                       // R4/R11 long run under stalls
    for (int i = 0; i < 20; i++) send(32'h1234_0000 + i);
    send(32'hF000_0000);                       // R10 stays set
    send(32'h4002_0001);
    repeat (30) @(posedge clk);
    chk(exp_q.size() == 0 && mode == 0, "R9", 64'(exp_q.size()), 64'd0);
    summary; $finish;
  end
endmodule